// File: doc/BRIEF.md
# Windowed Partition Address Translator

This block sits between a host that uses a fixed virtual address map and a bus master that reaches a compact physical space. Software programs four address windows, each a 32-bit start and a 32-bit size, through a small select/write register port. Only the first two windows take part in translation: a memory window and a register window. In the physical space these two are packed back to back. The memory window occupies offsets from zero upward. The register window follows directly, at an offset equal to the memory window's size.

Each valid request carries a virtual address. One clock later the block presents the physical address and a miss flag. The miss flag is raised when the address lies in neither translating window. The third and fourth windows are stored and can be read back, but they never change a translation. A configuration write takes effect on requests presented after the clock edge that performs it.

Top module: `win_xlate`

## Requirements
- R1: Reset (synchronous, active high) clears out_valid, out_paddr, out_miss and all eight configuration registers to zero.
- R2: A request with req_valid high produces out_valid high exactly one cycle later; out_valid is low in a cycle following no request.
- R3: When start_reg <= vaddr < start_reg + size_reg, out_paddr = vaddr - start_reg + size_mem (modulo 2^32).
- R4: Any other address gives out_paddr = vaddr - start_mem (modulo 2^32).
- R5: The register-window test includes its start address and excludes start plus size.
- R6: out_miss is 1 exactly when the address is outside the register window and also either below start_mem or at/above start_mem + size_mem; out_miss is 0 whenever out_valid is 0.
- R7: When the two windows overlap, the register-window mapping wins and out_miss is 0.
- R8: cfg_sel selects a register as 2*w + f, where w=0 memory, w=1 register, w=2 second memory and w=3 third memory, and f=0 start, f=1 size. A write with cfg_we stores cfg_wdata. cfg_rdata shows, one cycle later, the selected register's value from before any write in that same cycle.
- R9: Values written to windows 2 and 3 are stored and read back, but have no effect on out_paddr or out_miss.
- R10: A request presented in the same cycle as a configuration write is translated with the old configuration; the next request uses the new one.
- R11: Window end bounds are computed without wrap-around, so a window that ends exactly at 2^32 covers its top address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 3 | Configuration register select (2*window + field) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Registered readback of the selected register |
| req_valid | input | 1 | Virtual address request valid |
| req_vaddr | input | 32 | Virtual address |
| out_valid | output | 1 | Physical address valid |
| out_paddr | output | 32 | Translated physical address |
| out_miss | output | 1 | Address outside both translating windows |

## Verification
The bench builds the block with its default parameters: four windows and 32-bit addresses. This puts the full 33-bit bound arithmetic within reach, including windows that end exactly at the top of the address space and subtractions that wrap below zero. Random windows are placed close to the random addresses, so hits, misses, overlaps and exact boundary addresses all occur. Configuration writes are issued in the same cycle as requests to exercise the old-versus-new configuration ordering.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int XL_AW = 32;

  typedef struct packed {
    logic [XL_AW-1:0] start;
    logic [XL_AW-1:0] size;
  } win_t;
endpackage

// File: rtl/xlate_cfg_bank.sv
module xlate_cfg_bank
  import xlate_pkg::*;
#(
  parameter int NWIN  = 4,
  parameter int SEL_W = $clog2(2*NWIN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  logic [XL_AW-1:0] wdata,
  output logic [XL_AW-1:0] rdata,
  output win_t             mem_win,
  output win_t             reg_win
);
  localparam int NREG = 2*NWIN;

  logic [XL_AW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) regs_q[g] <= '0;
      else if (we && (int'(sel) == g)) regs_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (int'(sel) < NREG) rdata <= regs_q[sel];
    else rdata <= '0;
  end

  assign mem_win = '{start: regs_q[0], size: regs_q[1]};
  assign reg_win = '{start: regs_q[2], size: regs_q[3]};
endmodule

// File: rtl/xlate_map.sv
module xlate_map
  import xlate_pkg::*;
(
  input  logic [XL_AW-1:0] vaddr,
  input  win_t             mem_win,
  input  win_t             reg_win,
  output logic [XL_AW-1:0] paddr,
  output logic             miss
);
  logic [XL_AW:0] v_w, reg_lo, reg_hi, mem_lo, mem_hi;
  logic           in_reg, in_mem;

  always_comb begin
    v_w    = {1'b0, vaddr};
    reg_lo = {1'b0, reg_win.start};
    reg_hi = reg_lo + {1'b0, reg_win.size};
    mem_lo = {1'b0, mem_win.start};
    mem_hi = mem_lo + {1'b0, mem_win.size};
    in_reg = (v_w >= reg_lo) && (v_w < reg_hi);
    in_mem = (v_w >= mem_lo) && (v_w < mem_hi);
    if (in_reg) paddr = vaddr - reg_win.start + mem_win.size;
    else        paddr = vaddr - mem_win.start;
    miss = !in_reg && !in_mem;
  end
endmodule

// File: rtl/win_xlate.sv
module win_xlate
  import xlate_pkg::*;
#(
  parameter int NWIN  = 4,
  parameter int AW    = XL_AW,
  parameter int SEL_W = $clog2(2*NWIN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [AW-1:0]    cfg_wdata,
  output logic [AW-1:0]    cfg_rdata,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_vaddr,
  output logic             out_valid,
  output logic [AW-1:0]    out_paddr,
  output logic             out_miss
);
  win_t          mem_w, reg_w;
  logic [AW-1:0] paddr_c;
  logic          miss_c;

  xlate_cfg_bank #(.NWIN(NWIN), .SEL_W(SEL_W)) bank_i (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .mem_win(mem_w), .reg_win(reg_w)
  );

  xlate_map map_i (
    .vaddr(req_vaddr), .mem_win(mem_w), .reg_win(reg_w),
    .paddr(paddr_c), .miss(miss_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_paddr <= '0;
      out_miss  <= 1'b0;
    end else begin
      out_valid <= req_valid;
      out_miss  <= req_valid && miss_c;
      if (req_valid) out_paddr <= paddr_c;
    end
  end
endmodule

// File: rtl/win_xlate_chk.sv
module win_xlate_chk
  import xlate_pkg::*;
#(
  parameter int AW = XL_AW
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [AW-1:0] req_vaddr,
  input logic          out_valid,
  input logic [AW-1:0] out_paddr,
  input logic          out_miss,
  input win_t          mem_w,
  input win_t          reg_w
);
  logic          hit_reg;
  logic [AW-1:0] reg_map;

  assign hit_reg = ({1'b0, req_vaddr} >= {1'b0, reg_w.start}) &&
                   ({1'b0, req_vaddr} < ({1'b0, reg_w.start} + {1'b0, reg_w.size}));
  assign reg_map = req_vaddr - reg_w.start + mem_w.size;

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> !out_valid && !out_miss);

  // R2
  req_latency_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);

  // R2
  no_req_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);

  // R6
  miss_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_miss |-> out_valid);

  // R3
  reg_window_map_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && hit_reg |=> out_paddr == $past(reg_map) && !out_miss);
endmodule

bind win_xlate win_xlate_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .out_valid(out_valid), .out_paddr(out_paddr), .out_miss(out_miss),
  .mem_w(mem_w), .reg_w(reg_w)
);

// File: tb/win_xlate_tb_top.sv
module win_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        out_valid;
  logic [31:0] out_paddr;
  logic        out_miss;

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] model [8];

  always #5 clk = ~clk;

  win_xlate dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .out_valid(out_valid), .out_paddr(out_paddr), .out_miss(out_miss)
  );

  function automatic logic in_win(logic [31:0] a, logic [31:0] s, logic [31:0] z);
    logic [32:0] e;
    e = {1'b0, s} + {1'b0, z};
    return ({1'b0, a} >= {1'b0, s}) && ({1'b0, a} < e);
  endfunction

  function automatic logic [31:0] exp_paddr(logic [31:0] a);
    if (in_win(a, model[2], model[3])) return a - model[2] + model[1];
    return a - model[0];
  endfunction

  function automatic logic exp_miss(logic [31:0] a);
    return !in_win(a, model[2], model[3]) && !in_win(a, model[0], model[1]);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: optional write, optional request, and readback of sel
  task automatic step(string req, logic we, logic [2:0] sel, logic [31:0] wd,
                      logic rv, logic [31:0] va);
    logic [31:0] ep, er;
    logic        em;
    @(negedge clk);
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    req_valid = rv; req_vaddr = va;
    ep = exp_paddr(va);   // R10: old configuration applies
    em = exp_miss(va);
    er = model[sel];      // R8: readback shows pre-write value
    @(posedge clk);
    if (we) model[sel] = wd;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    chk({req, " valid"}, {31'd0, out_valid}, {31'd0, rv});
    if (rv) begin
      chk({req, " paddr"}, out_paddr, ep);
      chk({req, " miss"}, {31'd0, out_miss}, {31'd0, em});
    end else begin
      chk({req, " idle miss"}, {31'd0, out_miss}, 32'd0);
    end
    chk({req, " rdata"}, cfg_rdata, er);
  endtask

  task automatic wr(logic [2:0] sel, logic [31:0] v);
    step("R8", 1'b1, sel, v, 1'b0, '0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 valid", {31'd0, out_valid}, 32'd0);
    chk("R1 paddr", out_paddr, 32'd0);
    chk("R1 miss", {31'd0, out_miss}, 32'd0);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) step("R1 cfg zero", 1'b0, 3'(i), '0, 1'b0, '0);

    // directed windows: mem 0x1000+0x800, reg 0x4000+0x100
    wr(3'd0, 32'h1000); wr(3'd1, 32'h800); wr(3'd2, 32'h4000); wr(3'd3, 32'h100);
    step("R3", 1'b0, 3'd0, '0, 1'b1, 32'h4000);       // -> 0x800
    step("R5 upper in", 1'b0, 3'd1, '0, 1'b1, 32'h40FF);
    step("R5 upper out", 1'b0, 3'd2, '0, 1'b1, 32'h4100);
    step("R5 lower out", 1'b0, 3'd3, '0, 1'b1, 32'h3FFF);
    step("R4", 1'b0, 3'd0, '0, 1'b1, 32'h1000);       // -> 0
    step("R6 mem end", 1'b0, 3'd0, '0, 1'b1, 32'h1800);
    step("R4 wrap", 1'b0, 3'd0, '0, 1'b1, 32'h0FFF);  // -> 0xFFFFFFFF miss
    step("R2 idle", 1'b0, 3'd0, '0, 1'b0, 32'h1200);
    // R9: windows 2 and 3 stored but inert
    wr(3'd4, 32'h4000); wr(3'd5, 32'h10); wr(3'd6, 32'h0); wr(3'd7, 32'hFFFF_FFFF);
    step("R9 read w2", 1'b0, 3'd4, '0, 1'b1, 32'h4080);
    step("R9 read w3", 1'b0, 3'd7, '0, 1'b1, 32'h0000_0010);
    // R7: overlap, reg window inside mem window
    wr(3'd1, 32'h8000);
    step("R7", 1'b0, 3'd2, '0, 1'b1, 32'h4010);
    // R10: write with request in same cycle
    step("R10 old", 1'b1, 3'd0, 32'h2000, 1'b1, 32'h2100);
    step("R10 new", 1'b0, 3'd0, '0, 1'b1, 32'h2100);
    // R11: register window ends at 2^32
    wr(3'd2, 32'hFFFF_FF00); wr(3'd3, 32'h100);
    step("R11 top", 1'b0, 3'd2, '0, 1'b1, 32'hFFFF_FFFF);
    step("R11 below", 1'b0, 3'd3, '0, 1'b1, 32'hFFFF_FEFF);

    // constrained random
    void'($urandom(32'd20240611));
    for (int i = 0; i < 400; i++) begin
      logic [31:0] base, va;
      logic [2:0]  s;
      base = model[{$urandom_range(0, 1), 1'b0}];
      va = base + 32'($urandom_range(0, 600)) - 32'd100;
      if ($urandom_range(0, 9) == 0) va = $urandom();
      s = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 3) == 0)
        step("R3/R4/R6 rnd", 1'b1, s,
             (s[0] ? 32'($urandom_range(0, 512)) : ($urandom() & 32'hFFFF_FFF0)),
             1'($urandom_range(0, 1)), va);
      else
        step("R3/R4/R6 rnd", 1'b0, s, '0, 1'b1, va);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule